// File: doc/BRIEF.md
# Linear CCD Readout Timing Sequencer

The block drives a 256-pixel linear CCD sensor from a fast system clock. For every line it issues a transfer-gate pulse that moves the exposed charge into the sensor's shift register. It then issues a train of pixel shift clocks. Alongside these it produces framing information: a pixel index, a classification of every pixel as dummy, optical black or effective, markers for the first and last framed pixel, and a one-cycle strobe that tells a downstream converter when the analog output has settled.

The pixel rate comes from a half-period divider. The value on `halfDiv` is captured when a line is accepted and is never taken below a floor of `MIN_HALF`. A mode input selects between two line formats. With the internal sample-hold in use the line is one pixel longer, because one extra leading dummy comes first. A line is started by a request pulse. When free-run is held high, lines follow each other back to back.

Timing around the transfer gate is fixed by parameters, in system clocks:
- `GAP_CYC` sets the quiet gap before and after the gate.
- `GATE_CYC` sets the gate width.
- `STROBE_DLY` sets the strobe offset from each pixel clock rising edge.

Top module: `ccd_line_seq`

## Requirements
- R1: After reset, readoutGate, pixClk and adcStrobe are low, and pixIdx, lineStart, lineEnd and all three type flags are 0. They stay that way while startReq and freeRun are both low.
- R2: While idle, a clock edge that samples startReq high (or freeRun high) accepts a line. readoutGate rises GAP_CYC clock edges later and stays high for exactly GATE_CYC system clocks.
- R3: pixClk is low throughout the GAP_CYC cycles before the gate and throughout the gate. Exactly GAP_CYC low cycles separate the fall of readoutGate from the first pixClk rise.
- R4: The pixel clock has a period of 2·H system clocks and is high for the first H of them. H is halfDiv captured at line acceptance, raised to MIN_HALF if it is smaller.
- R5: Each line carries exactly MIN_PULSES (280) pixel-clock pulses. When freeRun is low at the end of the last pulse period, the sequencer returns to idle with every output low.
- R6: When freeRun is high at the end of the last pulse period, the next line is accepted on that edge. Its gate follows after GAP_CYC cycles, with no idle cycle in between.
- R7: Without sample-hold (shMode=0) the line has 273 framed pixels. Index 0..6 and 11 are dummy, 7..10 are optical black, 12..267 are effective and 268..272 are dummy. Padding indices 273..279 raise no flag.
- R8: With sample-hold (shMode=1) the line has 274 framed pixels. Index 0..7 and 12 are dummy, 8..11 are optical black, 13..268 are effective and 269..273 are dummy. Padding indices 274..279 raise no flag.
- R9: During the n-th pixel-clock period of a line (n counted from 0), pixIdx equals n. lineStart is high only at index 0 and lineEnd only at the last framed index. pixIdx is 0 outside the pixel train.
- R10: adcStrobe is a one-cycle pulse exactly STROBE_DLY system clocks after each pixClk rise, for framed pixels only. It never fires for padding pixels.
- R11: Changes on shMode and halfDiv after a line has been accepted have no effect on that line.
- R12: startReq high while a line is in progress is ignored, including on the final cycle of the line. With freeRun low, no extra gate follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request for one line while idle |
| freeRun | input | 1 | Back-to-back line operation when high |
| shMode | input | 1 | 1 = sample-hold line format, 0 = plain format |
| halfDiv | input | DIV_W | Pixel clock half period in system clocks |
| readoutGate | output | 1 | Charge transfer gate pulse |
| pixClk | output | 1 | Pixel shift clock |
| adcStrobe | output | 1 | Converter sample strobe |
| pixIdx | output | $clog2(MIN_PULSES) | Index of the current pixel within the line |
| pixDummy | output | 1 | Current pixel is a dummy |
| pixOb | output | 1 | Current pixel is optical black |
| pixEff | output | 1 | Current pixel is effective |
| lineStart | output | 1 | First framed pixel |
| lineEnd | output | 1 | Last framed pixel |

## Verification
Two events can land on the same edge: the end-of-line decision, which either relaunches a line or returns to idle, and an arriving start request or configuration change. The bench raises startReq exactly on the final cycle of a line, and changes mode and divider in the middle of a line. It then judges, cycle by cycle, that no gate follows and that the running line keeps the captured format. A second coincidence occurs when the strobe delay equals the last cycle of a pixel period, so the strobe shares its cycle with the index advance. The bench compares every cycle against an arithmetic model of the line and checks that the strobe belongs to the pixel that is ending.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_GATE = 3'd2,
    ST_POST = 3'd3,
    ST_RUN  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;  // capture mode and divider this edge
    logic runPix;   // pixel train active
  } seqCtrl_t;

endpackage

// File: rtl/ccd_pix_class.sv
module ccd_pix_class #(
  parameter int IDX_W     = 9,
  parameter int LEAD_BASE = 12,
  parameter int OB_PIX    = 4,
  parameter int OB_TAIL   = 1,
  parameter int EFF_PIX   = 256,
  parameter int TRAIL_PIX = 5
) (
  input  logic             active,
  input  logic             shSel,
  input  logic [IDX_W-1:0] idx,
  output logic             framed,
  output logic             isDummy,
  output logic             isOb,
  output logic             isEff,
  output logic             isFirst,
  output logic             isLast
);
  localparam int W = IDX_W + 1;

  logic [W-1:0] lead, obHi, obLo, effHi, lineLen, idxW;

  always_comb begin
    idxW    = {1'b0, idx};
    lead    = W'(LEAD_BASE) + {{IDX_W{1'b0}}, shSel};
    obHi    = lead - W'(OB_TAIL);
    obLo    = obHi - W'(OB_PIX);
    effHi   = lead + W'(EFF_PIX);
    lineLen = effHi + W'(TRAIL_PIX);
  end

  always_comb begin
    framed  = active && (idxW < lineLen);
    isOb    = framed && (idxW >= obLo) && (idxW < obHi);
    isEff   = framed && (idxW >= lead) && (idxW < effHi);
    isDummy = framed && !isOb && !isEff;
    isFirst = framed && (idxW == '0);
    isLast  = framed && (idxW == lineLen - W'(1));
  end

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int GAP_CYC  = 30,
  parameter int GATE_CYC = 50
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     freeRun,
  input  logic     lineDone,
  output seqCtrl_t ctrl,
  output logic     readoutGate
);
  localparam int CNT_MAX = (GAP_CYC > GATE_CYC) ? GAP_CYC : GATE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] GATE_LAST = CNT_W'(GATE_CYC - 1);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startReq || freeRun) stateNext = ST_PRE;
      ST_PRE:  if (cnt == GAP_LAST)     stateNext = ST_GATE;
      ST_GATE: if (cnt == GATE_LAST)    stateNext = ST_POST;
      ST_POST: if (cnt == GAP_LAST)     stateNext = ST_RUN;
      ST_RUN:  if (lineDone)            stateNext = freeRun ? ST_PRE : ST_IDLE;
      default:                          stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (stateNext != state || state == ST_IDLE || state == ST_RUN)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.loadCfg = (stateNext == ST_PRE) && (state != ST_PRE);
    ctrl.runPix  = (state == ST_RUN);
    readoutGate  = (state == ST_GATE);
  end

  // gate width watcher
  logic [CNT_W:0] gateLen;
  always_ff @(posedge clk) begin
    if (!rstN)            gateLen <= '0;
    else if (readoutGate) gateLen <= gateLen + 1'b1;
    else                  gateLen <= '0;
  end

  p_gate_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readoutGate) |-> gateLen == (CNT_W+1)'(GATE_CYC));

  p_load_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadCfg |=> !ctrl.runPix && !readoutGate);

endmodule

// File: rtl/ccd_seq_dp.sv
module ccd_seq_dp
  import ccd_seq_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int MIN_HALF   = 13,
  parameter int STROBE_DLY = 12,
  parameter int MIN_PULSES = 280,
  parameter int LEAD_BASE  = 12,
  parameter int OB_PIX     = 4,
  parameter int OB_TAIL    = 1,
  parameter int EFF_PIX    = 256,
  parameter int TRAIL_PIX  = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqCtrl_t                      ctrl,
  input  logic                          shMode,
  input  logic [DIV_W-1:0]              halfDiv,
  output logic                          lineDone,
  output logic                          pixClk,
  output logic                          adcStrobe,
  output logic [$clog2(MIN_PULSES)-1:0] pixIdx,
  output logic                          pixDummy,
  output logic                          pixOb,
  output logic                          pixEff,
  output logic                          lineStart,
  output logic                          lineEnd
);
  localparam int IDX_W = $clog2(MIN_PULSES);
  localparam int PH_W  = DIV_W + 1;
  localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(MIN_HALF);
  localparam logic [IDX_W-1:0] CNT_LAST   = IDX_W'(MIN_PULSES - 1);

  logic [DIV_W-1:0] halfQ, halfNext;
  logic             shQ;
  logic [PH_W-1:0]  phase, periodLast;
  logic [IDX_W-1:0] pixCnt;
  logic             pixLast, framed;

  always_comb begin
    halfNext   = (halfDiv < HALF_FLOOR) ? HALF_FLOOR : halfDiv;
    periodLast = {halfQ, 1'b0} - PH_W'(1);
    pixLast    = ctrl.runPix && (phase == periodLast);
    lineDone   = pixLast && (pixCnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfQ  <= HALF_FLOOR;
      shQ    <= 1'b0;
      phase  <= '0;
      pixCnt <= '0;
    end else begin
      if (ctrl.loadCfg) begin
        halfQ <= halfNext;
        shQ   <= shMode;
      end
      if (!ctrl.runPix) begin
        phase  <= '0;
        pixCnt <= '0;
      end else if (pixLast) begin
        phase  <= '0;
        pixCnt <= pixCnt + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  ccd_pix_class #(
    .IDX_W    (IDX_W),
    .LEAD_BASE(LEAD_BASE),
    .OB_PIX   (OB_PIX),
    .OB_TAIL  (OB_TAIL),
    .EFF_PIX  (EFF_PIX),
    .TRAIL_PIX(TRAIL_PIX)
  ) i_class (
    .active (ctrl.runPix),
    .shSel  (shQ),
    .idx    (pixCnt),
    .framed (framed),
    .isDummy(pixDummy),
    .isOb   (pixOb),
    .isEff  (pixEff),
    .isFirst(lineStart),
    .isLast (lineEnd)
  );

  always_comb begin
    pixClk    = ctrl.runPix && (phase < {1'b0, halfQ});
    adcStrobe = framed && (phase == PH_W'(STROBE_DLY));
    pixIdx    = ctrl.runPix ? pixCnt : '0;
  end

  // high-phase length watcher
  logic [PH_W-1:0] hiLen;
  always_ff @(posedge clk) begin
    if (!rstN)       hiLen <= '0;
    else if (pixClk) hiLen <= hiLen + 1'b1;
    else             hiLen <= '0;
  end

  p_high_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pixClk) |-> hiLen == {1'b0, halfQ});

  p_half_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    halfQ >= HALF_FLOOR);

  p_flag_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    framed |-> $countones({pixDummy, pixOb, pixEff}) == 1);

  p_pad_blank_r8: assert property (@(posedge clk) disable iff (!rstN)
    !framed |-> !(pixDummy || pixOb || pixEff || adcStrobe || lineStart || lineEnd));

  p_idx_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.runPix && $past(ctrl.runPix) && !$stable(pixIdx) |-> pixIdx == $past(pixIdx) + 1'b1);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    adcStrobe |=> !adcStrobe);

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_seq_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int MIN_HALF   = 13,
  parameter int GAP_CYC    = 30,
  parameter int GATE_CYC   = 50,
  parameter int STROBE_DLY = 12,
  parameter int MIN_PULSES = 280,
  parameter int LEAD_BASE  = 12,
  parameter int OB_PIX     = 4,
  parameter int OB_TAIL    = 1,
  parameter int EFF_PIX    = 256,
  parameter int TRAIL_PIX  = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startReq,
  input  logic                          freeRun,
  input  logic                          shMode,
  input  logic [DIV_W-1:0]              halfDiv,
  output logic                          readoutGate,
  output logic                          pixClk,
  output logic                          adcStrobe,
  output logic [$clog2(MIN_PULSES)-1:0] pixIdx,
  output logic                          pixDummy,
  output logic                          pixOb,
  output logic                          pixEff,
  output logic                          lineStart,
  output logic                          lineEnd
);
  seqCtrl_t ctrl;
  logic     lineDone;

  ccd_seq_ctrl #(
    .GAP_CYC (GAP_CYC),
    .GATE_CYC(GATE_CYC)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .freeRun    (freeRun),
    .lineDone   (lineDone),
    .ctrl       (ctrl),
    .readoutGate(readoutGate)
  );

  ccd_seq_dp #(
    .DIV_W     (DIV_W),
    .MIN_HALF  (MIN_HALF),
    .STROBE_DLY(STROBE_DLY),
    .MIN_PULSES(MIN_PULSES),
    .LEAD_BASE (LEAD_BASE),
    .OB_PIX    (OB_PIX),
    .OB_TAIL   (OB_TAIL),
    .EFF_PIX   (EFF_PIX),
    .TRAIL_PIX (TRAIL_PIX)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .shMode   (shMode),
    .halfDiv  (halfDiv),
    .lineDone (lineDone),
    .pixClk   (pixClk),
    .adcStrobe(adcStrobe),
    .pixIdx   (pixIdx),
    .pixDummy (pixDummy),
    .pixOb    (pixOb),
    .pixEff   (pixEff),
    .lineStart(lineStart),
    .lineEnd  (lineEnd)
  );

  // cross-module timing watchers
  localparam int GAPW = $clog2(GAP_CYC + 1);
  localparam int PCW  = $clog2(MIN_PULSES + 1);
  localparam logic [GAPW-1:0] GAP_SAT   = GAPW'(GAP_CYC);
  localparam logic [PCW-1:0]  PULSE_SAT = PCW'(MIN_PULSES);

  logic [GAPW-1:0] lowLen, sinceGate;
  logic [PCW-1:0]  pulseCnt;
  logic            seenGate, clkD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowLen    <= GAP_SAT;
      sinceGate <= GAP_SAT;
      pulseCnt  <= '0;
      seenGate  <= 1'b0;
      clkD      <= 1'b0;
    end else begin
      clkD <= pixClk;
      if (pixClk)                 lowLen <= '0;
      else if (lowLen != GAP_SAT) lowLen <= lowLen + 1'b1;
      if (readoutGate)               sinceGate <= '0;
      else if (sinceGate != GAP_SAT) sinceGate <= sinceGate + 1'b1;
      if (readoutGate)                                   pulseCnt <= '0;
      else if (pixClk && !clkD && pulseCnt != PULSE_SAT) pulseCnt <= pulseCnt + 1'b1;
      if (readoutGate) seenGate <= 1'b1;
    end
  end

  p_gate_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    readoutGate |-> !pixClk && !adcStrobe);

  p_gap_before_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readoutGate) |-> lowLen >= GAP_SAT);

  p_gap_after_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pixClk) |-> sinceGate >= GAP_SAT);

  p_pulse_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readoutGate) && seenGate |-> pulseCnt >= PULSE_SAT);

endmodule

// File: tb/test_ccd_line_seq.sv
module test_ccd_line_seq;
  localparam int CLK_NS = 20;
  localparam int DIV_W  = 4;
  localparam int MINH   = 2;
  localparam int GAP    = 3;
  localparam int GATE   = 4;
  localparam int SDLY   = 3;
  localparam int NPULSE = 280;
  localparam int TAIL   = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, freeRun = 1'b0, shMode = 1'b0;
  logic [DIV_W-1:0] halfDiv = '0;
  logic readoutGate, pixClk, adcStrobe, pixDummy, pixOb, pixEff, lineStart, lineEnd;
  logic [8:0] pixIdx;

  int nChecks = 0, nFail = 0;
  int errN[7], errA[7], errE[7], errK[7];

  always #(CLK_NS/2) clk = ~clk;

  ccd_line_seq #(
    .DIV_W(DIV_W), .MIN_HALF(MINH), .GAP_CYC(GAP), .GATE_CYC(GATE),
    .STROBE_DLY(SDLY), .MIN_PULSES(NPULSE)
  ) i_ccd_line_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .freeRun(freeRun),
    .shMode(shMode), .halfDiv(halfDiv), .readoutGate(readoutGate),
    .pixClk(pixClk), .adcStrobe(adcStrobe), .pixIdx(pixIdx),
    .pixDummy(pixDummy), .pixOb(pixOb), .pixEff(pixEff),
    .lineStart(lineStart), .lineEnd(lineEnd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic note(input int f, input int act, input int exp, input int k);
    if (act != exp) begin
      if (errN[f] == 0) begin errA[f] = act; errE[f] = exp; errK[f] = k; end
      errN[f]++;
    end
  endtask

  task automatic runLines(input bit sh, input int hv, input int nLines, input bit free,
                          input bit scramble, input string fmtTag, input string gateTag,
                          input string tailTag);
    int h, lineCyc, total, lead, len, kk, r, pix, ph;
    bit run;
    string tg[7];
    h = (hv < MINH) ? MINH : hv;
    lineCyc = 2*GAP + GATE + NPULSE*2*h;
    total = nLines * lineCyc;
    lead = 12 + sh;
    len = lead + 256 + 5;
    tg = '{gateTag, "R3", "R4", "R9", fmtTag, "R10", tailTag};
    for (int f = 0; f < 7; f++) errN[f] = 0;
    @(negedge clk);
    shMode = sh; halfDiv = DIV_W'(hv); freeRun = free; startReq = 1'b1;
    @(posedge clk);
    for (int k = 0; k < total + TAIL; k++) begin
      @(negedge clk);
      if (k < total) begin
        kk = k % lineCyc;
        run = (kk >= 2*GAP + GATE);
        r = kk - (2*GAP + GATE);
        pix = run ? r / (2*h) : 0;
        ph = run ? r % (2*h) : 0;
        note(0, int'(readoutGate), int'(kk >= GAP && kk < GAP + GATE), k);
        if (!run) note(1, int'(pixClk), 0, k);
        else      note(2, int'(pixClk), int'(ph < h), k);
        note(3, int'({pixIdx, lineStart, lineEnd}),
             int'({9'(pix), run && pix == 0, run && pix == len - 1}), k);
        note(4, int'({pixDummy, pixOb, pixEff}),
             (!run || pix >= len) ? 0 :
             (pix >= lead && pix < lead + 256) ? 1 :
             (pix >= lead - 5 && pix < lead - 1) ? 2 : 4, k);
        note(5, int'(adcStrobe), int'(run && ph == SDLY && pix < len), k);
      end else begin
        note(6, int'({readoutGate, pixClk, adcStrobe, pixIdx, pixDummy, pixOb, pixEff,
                      lineStart, lineEnd}), 0, k);
      end
      if (k == 0) startReq = 1'b0;
      if (free && k == total - lineCyc + 5) freeRun = 1'b0;
      if (scramble) begin
        if (k == 2) begin shMode = ~sh; halfDiv = DIV_W'(hv ^ 5); end
        if (k == 20) startReq = 1'b1;
        if (k == 21) startReq = 1'b0;
        if (k == total - 1) startReq = 1'b1;
        if (k == total) startReq = 1'b0;
      end
    end
    for (int f = 0; f < 7; f++) begin
      if (errN[f] != 0) $display("  first mismatch field %0d at sample %0d", f, errK[f]);
      check(errN[f] == 0, tg[f], errA[f], errE[f]);
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: quiet after reset and while no request
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(readoutGate == 0, "R1 gate", int'(readoutGate), 0);
      check({pixClk, adcStrobe} == 0, "R1 clk/strobe", int'({pixClk, adcStrobe}), 0);
      check({pixIdx, pixDummy, pixOb, pixEff, lineStart, lineEnd} == 0, "R1 frame",
            int'({pixIdx, pixDummy, pixOb, pixEff, lineStart, lineEnd}), 0);
    end
    // single lines, both formats, divider sweep including clamped values
    for (int s = 0; s < 2; s++) begin
      foreach (hvList[j]) runLines(s[0], hvList[j], 1, 1'b0, 1'b0, s ? "R8" : "R7", "R2", "R5");
    end
    // back-to-back lines
    runLines(1'b1, 2, 3, 1'b1, 1'b0, "R8", "R6", "R5");
    runLines(1'b0, 3, 2, 1'b1, 1'b0, "R7", "R6", "R5");
    // mid-line config changes and stray requests
    runLines(1'b0, 2, 1, 1'b0, 1'b1, "R11", "R2", "R12");
    runLines(1'b1, 3, 1, 1'b0, 1'b1, "R11", "R2", "R12");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  int hvList[5] = '{0, 1, 2, 3, 7};

endmodule